// File: doc/BRIEF.md
# Open Page Tracking Table

This block keeps, for one memory channel, a record of which DRAM banks currently hold an open row and which row that is. The table has one entry per bank of every rank: four ranks of up to eight banks, 32 entries. A scheduler drives row-open (activate), single-bank close (precharge), rank-wide close (precharge-all) and refresh events into it as it issues them. It also presents the rank, bank and row of a pending request, and the table answers in the same cycle. The answer is one of three classes: page hit, page miss or page empty. The table also returns the row held open in the addressed bank.

One static input selects between devices with eight banks and devices with four banks. In four-bank mode the top bit of every bank index is dropped, so the upper half of each rank's entries is never touched. A second instance covers a second channel, giving 64 tracked pages in all. Command timing is not modelled here; the only refresh effect is that refresh closes every page.

Top module: `page_track_table`

## Requirements
- R1: After reset every entry is closed: every lookup reports page empty and `cur_row` reads zero.
- R2: An activate to a rank/bank opens that entry and stores its row. From the next cycle, a lookup of that rank/bank with the same row reports hit, and `cur_row` equals the stored row.
- R3: A lookup of an open entry with a different row reports miss, and `cur_row` shows the row that is held open.
- R4: A precharge closes only the addressed entry; all other entries keep their state.
- R5: A precharge-all closes every bank of the addressed rank; the other ranks keep their state.
- R6: A refresh closes every entry of every rank.
- R7: With `bank8_mode` low (four-bank devices), bit 2 of the bank index is ignored on lookup, activate and precharge, so bank b and bank b+4 name the same entry. With `bank8_mode` high, all three bits are used.
- R8: When an activate and any close event address the same entry in one cycle, the activate wins: the entry is left open with the new row.
- R9: Exactly one of `pg_hit`, `pg_miss`, `pg_empty` is high at all times out of reset, and `cur_row` is zero whenever `pg_empty` is high.
- R10: The lookup is combinational on the table state. An event changes the lookup result only after the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, closes all entries |
| bank8_mode | input | 1 | 1: eight-bank devices, 0: four-bank devices |
| act_valid | input | 1 | Activate event |
| act_rank | input | 2 | Rank of activate |
| act_bank | input | 3 | Bank of activate |
| act_row | input | 15 | Row opened by activate |
| pre_valid | input | 1 | Single-bank precharge event |
| pre_rank | input | 2 | Rank of precharge |
| pre_bank | input | 3 | Bank of precharge |
| pre_all_valid | input | 1 | Precharge-all event for one rank |
| pre_all_rank | input | 2 | Rank closed by precharge-all |
| ref_valid | input | 1 | Refresh event, closes all entries |
| lk_rank | input | 2 | Lookup rank |
| lk_bank | input | 3 | Lookup bank |
| lk_row | input | 15 | Lookup row |
| pg_hit | output | 1 | Entry open with matching row |
| pg_miss | output | 1 | Entry open with a different row |
| pg_empty | output | 1 | Entry closed |
| cur_row | output | 15 | Row open in the looked-up entry, zero if closed |

## Verification
The cases that are hardest to reach from the ports are two. The first is an activate and a close that land on the same entry in one cycle. The second is a stale entry in the upper bank half left over from eight-bank operation after a switch to four-bank mode. Random traffic rarely lines these up. The bench therefore drives each of them as a directed case: it issues a precharge and an activate to one bank together, and it opens bank 6 in four-bank mode and then reads banks 2 and 6 back in both modes. The random phase draws rows from a small pool and alternates the mode, so hits, misses and aliased indices all recur.

// File: rtl/page_track_table.sv
module page_track_table #(
  parameter int RANKS = 4,
  parameter int BANKS = 8,
  parameter int ROW_W = 15
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bank8_mode,
  input  logic                     act_valid,
  input  logic [$clog2(RANKS)-1:0] act_rank,
  input  logic [$clog2(BANKS)-1:0] act_bank,
  input  logic [ROW_W-1:0]         act_row,
  input  logic                     pre_valid,
  input  logic [$clog2(RANKS)-1:0] pre_rank,
  input  logic [$clog2(BANKS)-1:0] pre_bank,
  input  logic                     pre_all_valid,
  input  logic [$clog2(RANKS)-1:0] pre_all_rank,
  input  logic                     ref_valid,
  input  logic [$clog2(RANKS)-1:0] lk_rank,
  input  logic [$clog2(BANKS)-1:0] lk_bank,
  input  logic [ROW_W-1:0]         lk_row,
  output logic                     pg_hit,
  output logic                     pg_miss,
  output logic                     pg_empty,
  output logic [ROW_W-1:0]         cur_row
);
  localparam int RANK_W  = $clog2(RANKS);
  localparam int BANK_W  = $clog2(BANKS);
  localparam int ENTRIES = RANKS * BANKS;
  localparam int IDX_W   = RANK_W + BANK_W;

  logic [BANK_W-1:0]             bmask;
  logic [IDX_W-1:0]              a_idx, p_idx, l_idx;
  logic [ENTRIES-1:0]            open_q;
  logic [ENTRIES-1:0][ROW_W-1:0] row_q;

  assign bmask = bank8_mode ? {BANK_W{1'b1}} : {1'b0, {(BANK_W-1){1'b1}}};
  assign a_idx = {act_rank, act_bank & bmask};
  assign p_idx = {pre_rank, pre_bank & bmask};
  assign l_idx = {lk_rank,  lk_bank  & bmask};

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    localparam logic [RANK_W-1:0] ER = RANK_W'(e / BANKS);
    logic do_act, do_cls;
    assign do_act = act_valid && (a_idx == IDX_W'(e));
    assign do_cls = ref_valid || (pre_all_valid && pre_all_rank == ER)
                 || (pre_valid && p_idx == IDX_W'(e));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        open_q[e] <= 1'b0;
        row_q[e]  <= '0;
      end else if (do_act) begin
        open_q[e] <= 1'b1;
        row_q[e]  <= act_row;
      end else if (do_cls) begin
        open_q[e] <= 1'b0;
      end
    end
  end

  logic l_open, l_match;
  assign l_open   = open_q[l_idx];
  assign l_match  = row_q[l_idx] == lk_row;
  assign pg_empty = !l_open;
  assign pg_hit   = l_open && l_match;
  assign pg_miss  = l_open && !l_match;
  assign cur_row  = l_open ? row_q[l_idx] : '0;
endmodule

// File: rtl/page_track_table_chk.sv
module page_track_table_chk #(
  parameter int RANKS = 4,
  parameter int BANKS = 8,
  parameter int ROW_W = 15
) (
  input logic                                      clk,
  input logic                                      rst_n,
  input logic                                      bank8_mode,
  input logic                                      act_valid,
  input logic [$clog2(RANKS)-1:0]                  act_rank,
  input logic [$clog2(BANKS)-1:0]                  act_bank,
  input logic [ROW_W-1:0]                          act_row,
  input logic                                      pre_valid,
  input logic [$clog2(RANKS)-1:0]                  pre_rank,
  input logic [$clog2(BANKS)-1:0]                  pre_bank,
  input logic                                      pre_all_valid,
  input logic [$clog2(RANKS)-1:0]                  pre_all_rank,
  input logic                                      ref_valid,
  input logic                                      pg_hit,
  input logic                                      pg_miss,
  input logic                                      pg_empty,
  input logic [ROW_W-1:0]                          cur_row,
  input logic [RANKS*BANKS-1:0]                    open_q,
  input logic [RANKS*BANKS-1:0][ROW_W-1:0]         row_q
);
  localparam int BANK_W = $clog2(BANKS);
  localparam int IDX_W  = $clog2(RANKS) + BANK_W;

  logic [IDX_W-1:0] a_ent, p_ent, pa_base;
  assign a_ent   = {act_rank, bank8_mode ? act_bank : {1'b0, act_bank[BANK_W-2:0]}};
  assign p_ent   = {pre_rank, bank8_mode ? pre_bank : {1'b0, pre_bank[BANK_W-2:0]}};
  assign pa_base = {pre_all_rank, {BANK_W{1'b0}}};

  assert_one_class_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({pg_hit, pg_miss, pg_empty}) == 1);

  assert_empty_row_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pg_empty |-> cur_row == '0);

  assert_act_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid |=> open_q[$past(a_ent)] && row_q[$past(a_ent)] == $past(act_row));

  assert_pre_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pre_valid && !(act_valid && a_ent == p_ent) |=> !open_q[$past(p_ent)]);

  assert_pre_all_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pre_all_valid && !(act_valid && act_rank == pre_all_rank)
      |=> open_q[$past(pa_base) +: BANKS] == '0);

  assert_ref_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid && !act_valid |=> open_q == '0);

  for (genvar r = 0; r < RANKS; r++) begin : g_rk
    for (genvar b = BANKS / 2; b < BANKS; b++) begin : g_hi
      assert_upper_unused_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bank8_mode |=> !$rose(open_q[r*BANKS+b]));
    end
  end
endmodule

bind page_track_table page_track_table_chk #(.RANKS(RANKS), .BANKS(BANKS), .ROW_W(ROW_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bank8_mode(bank8_mode),
  .act_valid(act_valid), .act_rank(act_rank), .act_bank(act_bank), .act_row(act_row),
  .pre_valid(pre_valid), .pre_rank(pre_rank), .pre_bank(pre_bank),
  .pre_all_valid(pre_all_valid), .pre_all_rank(pre_all_rank), .ref_valid(ref_valid),
  .pg_hit(pg_hit), .pg_miss(pg_miss), .pg_empty(pg_empty), .cur_row(cur_row),
  .open_q(open_q), .row_q(row_q)
);

// File: tb/page_track_table_tb_top.sv
module page_track_table_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bank8_mode = 1'b1;
  logic act_valid = 0, pre_valid = 0, pre_all_valid = 0, ref_valid = 0;
  logic [1:0] act_rank = 0, pre_rank = 0, pre_all_rank = 0, lk_rank = 0;
  logic [2:0] act_bank = 0, pre_bank = 0, lk_bank = 0;
  logic [14:0] act_row = 0, lk_row = 0;
  logic pg_hit, pg_miss, pg_empty;
  logic [14:0] cur_row;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_track_table dut_i (
    .clk(clk), .rst_n(rst_n), .bank8_mode(bank8_mode),
    .act_valid(act_valid), .act_rank(act_rank), .act_bank(act_bank), .act_row(act_row),
    .pre_valid(pre_valid), .pre_rank(pre_rank), .pre_bank(pre_bank),
    .pre_all_valid(pre_all_valid), .pre_all_rank(pre_all_rank), .ref_valid(ref_valid),
    .lk_rank(lk_rank), .lk_bank(lk_bank), .lk_row(lk_row),
    .pg_hit(pg_hit), .pg_miss(pg_miss), .pg_empty(pg_empty), .cur_row(cur_row)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  bit m_open [32];
  logic [14:0] m_row [32];

  function automatic int ent(logic [1:0] r, logic [2:0] b, bit m8);
    return int'(r) * 8 + (m8 ? int'(b) : int'(b) % 4);
  endfunction

  task automatic chk(bit ok, string tag, string what, int actv, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, actv, expv);
    end
  endtask

  task automatic check_lookup(string tag);
    int e;
    logic [2:0] exp_cls;
    logic [14:0] exp_row;
    e = ent(lk_rank, lk_bank, bank8_mode);
    if (!m_open[e]) begin exp_cls = 3'b001; exp_row = '0; end
    else begin
      exp_cls = (m_row[e] == lk_row) ? 3'b100 : 3'b010;
      exp_row = m_row[e];
    end
    chk({pg_hit, pg_miss, pg_empty} == exp_cls, tag, "class{hit,miss,empty}",
        int'({pg_hit, pg_miss, pg_empty}), int'(exp_cls));
    chk(cur_row == exp_row, tag, "cur_row", int'(cur_row), int'(exp_row));
  endtask

  task automatic look(logic [1:0] r, logic [2:0] b, logic [14:0] row, string tag);
    lk_rank = r; lk_bank = b; lk_row = row;
    #1;
    check_lookup(tag);
  endtask

  task automatic model_update();
    if (ref_valid) for (int i = 0; i < 32; i++) m_open[i] = 0;
    if (pre_all_valid) for (int i = 0; i < 8; i++) m_open[int'(pre_all_rank)*8+i] = 0;
    if (pre_valid) m_open[ent(pre_rank, pre_bank, bank8_mode)] = 0;
    if (act_valid) begin
      m_open[ent(act_rank, act_bank, bank8_mode)] = 1;
      m_row[ent(act_rank, act_bank, bank8_mode)] = act_row;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_update();
    @(negedge clk);
    act_valid = 0; pre_valid = 0; pre_all_valid = 0; ref_valid = 0;
  endtask

  task automatic do_act(logic [1:0] r, logic [2:0] b, logic [14:0] row);
    act_valid = 1; act_rank = r; act_bank = b; act_row = row;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    process::self().srandom(32'h5eed_1234);
    for (int i = 0; i < 32; i++) begin m_open[i] = 0; m_row[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: all entries empty after reset
    for (int r = 0; r < 4; r++)
      for (int b = 0; b < 8; b++) look(2'(r), 3'(b), 15'h0, "R1");

    // R10: activate not visible before the edge
    do_act(2'd1, 3'd3, 15'h123);
    look(2'd1, 3'd3, 15'h123, "R10");
    tick();
    look(2'd1, 3'd3, 15'h123, "R2");
    look(2'd1, 3'd3, 15'h124, "R3");

    // R4: precharge only closes its own entry
    do_act(2'd1, 3'd4, 15'h7);
    tick();
    pre_valid = 1; pre_rank = 2'd1; pre_bank = 3'd3;
    tick();
    look(2'd1, 3'd3, 15'h123, "R4");
    look(2'd1, 3'd4, 15'h7, "R4");

    // R5: precharge-all closes one rank only
    do_act(2'd0, 3'd2, 15'h9);
    tick();
    pre_all_valid = 1; pre_all_rank = 2'd1;
    tick();
    look(2'd1, 3'd4, 15'h7, "R5");
    look(2'd0, 3'd2, 15'h9, "R5");

    // R8: activate wins over same-cycle precharge and precharge-all
    do_act(2'd0, 3'd2, 15'h5);
    pre_valid = 1; pre_rank = 2'd0; pre_bank = 3'd2;
    pre_all_valid = 1; pre_all_rank = 2'd0;
    tick();
    look(2'd0, 3'd2, 15'h5, "R8");
    chk(pg_hit == 1'b1, "R8", "pg_hit", int'(pg_hit), 1);

    // R6: refresh closes everything
    do_act(2'd3, 3'd7, 15'h33);
    tick();
    ref_valid = 1;
    tick();
    look(2'd0, 3'd2, 15'h5, "R6");
    look(2'd3, 3'd7, 15'h33, "R6");

    // R7: four-bank aliasing of bank bit 2
    bank8_mode = 0;
    do_act(2'd2, 3'd6, 15'h55);
    tick();
    look(2'd2, 3'd2, 15'h55, "R7");
    look(2'd2, 3'd6, 15'h55, "R7");
    bank8_mode = 1;
    look(2'd2, 3'd6, 15'h55, "R7");
    look(2'd2, 3'd2, 15'h55, "R7");
    bank8_mode = 0;
    pre_valid = 1; pre_rank = 2'd2; pre_bank = 3'd6;
    tick();
    look(2'd2, 3'd2, 15'h55, "R7");

    // Random phase: R9 class and R2/R3/R4/R5/R6 state updates
    for (int cyc = 0; cyc < 4000; cyc++) begin
      int e;
      bank8_mode = ((cyc / 1000) % 2) == 0;
      if ($urandom_range(99) < 30) do_act(2'($urandom), 3'($urandom), 15'($urandom_range(3)));
      if ($urandom_range(99) < 15) begin
        pre_valid = 1; pre_rank = 2'($urandom); pre_bank = 3'($urandom);
      end
      if ($urandom_range(99) < 4) begin pre_all_valid = 1; pre_all_rank = 2'($urandom); end
      if ($urandom_range(99) < 2) ref_valid = 1;
      lk_rank = 2'($urandom); lk_bank = 3'($urandom);
      e = ent(lk_rank, lk_bank, bank8_mode);
      lk_row = ($urandom_range(1) == 1) ? m_row[e] : 15'($urandom_range(3));
      #1;
      check_lookup("R9");
      tick();
    end

    finish_run();
  end
endmodule